// File: doc/BRIEF.md
# Mailbox Receive Message Queue

This block is the receive side of an inter-processor mailbox. A remote producer hands in 64-bit messages, each tagged with a 3-bit source channel number, through a valid/ready port. The messages are held in a circular queue. The host works through a small register window. It reads the oldest message through three read-only registers: the channel, the low word and the high word. It then writes a pop command, which retires that message.

A status word shows the raw write and read positions and a full bit. Software uses these to work out how many messages are waiting: when the two positions are equal, the full bit tells a full queue from an empty one. A read-only capacity register returns the number of slots minus one. A single interrupt line signals that messages have arrived. It can be masked, and it is cleared by a register write. A clear command returns the queue to the empty state.

Top module: `mbx_rx_fifo`

## Requirements
- R1: After reset the status word reads 0, the interrupt status reads 0, the mask register reads 0x1F, `irq` is low and `in_ready` is high.
- R2: An accepted push (`in_valid` and `in_ready` high at a clock edge) stores the message at the write position and advances that position by one, modulo DEPTH. The head registers show the oldest message: offset 0x00 gives the channel in bits [2:0], offset 0x04 the low word and offset 0x08 the high word.
- R3: After DEPTH pushes without a pop, the full bit is set, the two positions are equal and `in_ready` is low. A refused push overwrites no entry.
- R4: A write to offset 0x0C with bit 0 set retires the head message and advances the read position by one, modulo DEPTH. A write to 0x0C with bit 0 clear has no effect.
- R5: A pop command while the queue is empty is ignored, and both positions stay unchanged.
- R6: The status word at offset 0x14 holds the read position in bits [31:24], the write position in bits [23:16] and the full bit in bit 0. All other bits read 0.
- R7: A push and a pop in the same cycle on a non-empty queue both take effect, and the full bit keeps its value.
- R8: Writing 0 to offset 0x10 returns both positions to 0 and clears the full bit, and `in_ready` is low in that cycle. Writing a nonzero value there has no effect.
- R9: Offset 0x24 reads DEPTH-1.
- R10: Offset 0x1C is a 5-bit mask register with reset value 0x1F. An accepted push sets the pending interrupt only while mask bit 0 is 0. `irq` is high when the pending bit is set and mask bit 0 is 0.
- R11: Offset 0x18 reads the pending bit in bit 0. Writing 1 to bit 0 of 0x18 clears the pending bit, but a push accepted in the same cycle keeps it set.
- R12: While the queue is empty, the three head registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Producer offers a message |
| in_ready | output | 1 | Block accepts the offered message |
| in_chan | input | 3 | Source channel of the offered message |
| in_lo | input | 32 | Low word of the offered message |
| in_hi | input | 32 | High word of the offered message |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| irq | output | 1 | Message-arrived interrupt |

## Verification
The assertions assume that register writes are single-cycle strobes with stable offset and data. They also assume that the producer's port is the only source of messages, so a shadow count built from accepted pushes, valid pops and clear writes tracks the true fill level. The bench drives every input on the falling clock edge and holds it for exactly one cycle. It never holds a write strobe longer than that, and it reads registers only while the write strobe is low. The head registers are read only after the bench has stated whether the queue is empty, and the empty case is checked against zero.

// File: rtl/mbx_rx_pkg.sv
// Package: shared widths, register offsets and the message record for the
// mailbox receive queue. Assumes a 6-bit byte-offset register window.
package mbx_rx_pkg;
    localparam int ID_W   = 3;
    localparam int WORD_W = 32;
    localparam int MASK_W = 5;
    localparam int ADDR_W = 6;
    localparam int POS_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CHAN  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_LO    = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_HI    = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_POP   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_IPEND = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_IMASK = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CAP   = 6'h24;

    typedef struct packed {
        logic [ID_W-1:0]   chan;
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } msg_t;
endpackage

// File: rtl/mbx_rx_store.sv
// Module: circular message storage with read/write positions and a full flag.
// Assumes the caller never pushes when full and never pops when empty;
// a clear has priority over both.
module mbx_rx_store
    import mbx_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_en,
    input  logic          pop_en,
    input  logic          clr_en,
    input  msg_t          push_msg,
    output msg_t          head_msg,
    output logic [AW-1:0] wr_pos,
    output logic [AW-1:0] rd_pos,
    output logic          full,
    output logic          empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    msg_t          slots [DEPTH];
    logic [AW-1:0] wr_nxt;
    logic [AW-1:0] rd_nxt;

    // Next positions, wrapping at the last slot.
    always_comb begin
        wr_nxt = (wr_pos == LAST) ? '0 : wr_pos + 1'b1;
        rd_nxt = (rd_pos == LAST) ? '0 : rd_pos + 1'b1;
    end

    // Message slots; written only by an accepted push.
    always_ff @(posedge clk) begin
        if (push_en && !clr_en) slots[wr_pos] <= push_msg;
    end

    // Positions and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_en) begin
            wr_pos <= '0;
            rd_pos <= '0;
            full   <= 1'b0;
        end else begin
            if (push_en) wr_pos <= wr_nxt;
            if (pop_en)  rd_pos <= rd_nxt;
            if (push_en && !pop_en && (wr_nxt == rd_pos)) full <= 1'b1;
            else if (pop_en && !push_en)                  full <= 1'b0;
        end
    end

    // Head view and empty flag.
    always_comb begin
        empty    = (wr_pos == rd_pos) && !full;
        head_msg = slots[rd_pos];
    end
endmodule

// File: rtl/mbx_rx_irq.sv
// Module: interrupt mask register and pending bit for message arrival.
// Assumes push_fire marks an accepted push; a set beats a clear.
module mbx_rx_irq
    import mbx_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [MASK_W-1:0] mask_wdata,
    input  logic              push_fire,
    input  logic              pend_clr,
    output logic [MASK_W-1:0] mask_q,
    output logic              pend_q,
    output logic              irq
);
    // Mask register, all sources masked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // Pending bit: set by an unmasked push, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                       pend_q <= 1'b0;
        else if (push_fire && !mask_q[0]) pend_q <= 1'b1;
        else if (pend_clr)                pend_q <= 1'b0;
    end

    // Interrupt line.
    always_comb irq = pend_q && !mask_q[0];
endmodule

// File: rtl/mbx_rx_fifo.sv
// Module: top of the mailbox receive queue. Decodes register writes into
// pop, clear, mask and interrupt-clear actions and muxes register reads.
// Assumes bus_wr is a one-cycle strobe; reads are combinational.
module mbx_rx_fifo
    import mbx_rx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [2:0]  in_chan,
    input  logic [31:0] in_lo,
    input  logic [31:0] in_hi,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    msg_t              head_msg;
    msg_t              push_msg;
    logic [AW-1:0]     wr_pos;
    logic [AW-1:0]     rd_pos;
    logic              full;
    logic              empty;
    logic              clr_en;
    logic              pop_en;
    logic              push_fire;
    logic              mask_wr;
    logic              pend_clr;
    logic [MASK_W-1:0] mask_q;
    logic              pend_q;

    // Write decode and push handshake.
    always_comb begin
        clr_en    = bus_wr && (bus_addr == OFS_CLR) && (bus_wdata == '0);
        pop_en    = bus_wr && (bus_addr == OFS_POP) && bus_wdata[0] && !empty && !clr_en;
        mask_wr   = bus_wr && (bus_addr == OFS_IMASK);
        pend_clr  = bus_wr && (bus_addr == OFS_IPEND) && bus_wdata[0];
        in_ready  = !full && !clr_en;
        push_fire = in_valid && in_ready;
        push_msg  = '{chan: in_chan, hi: in_hi, lo: in_lo};
    end

    mbx_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_fire),
        .pop_en   (pop_en),
        .clr_en   (clr_en),
        .push_msg (push_msg),
        .head_msg (head_msg),
        .wr_pos   (wr_pos),
        .rd_pos   (rd_pos),
        .full     (full),
        .empty    (empty)
    );

    mbx_rx_irq u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (bus_wdata[MASK_W-1:0]),
        .push_fire  (push_fire),
        .pend_clr   (pend_clr),
        .mask_q     (mask_q),
        .pend_q     (pend_q),
        .irq        (irq)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CHAN:  bus_rdata = empty ? '0 : 32'(head_msg.chan);
            OFS_LO:    bus_rdata = empty ? '0 : head_msg.lo;
            OFS_HI:    bus_rdata = empty ? '0 : head_msg.hi;
            OFS_STAT:  bus_rdata = {POS_W'(rd_pos), POS_W'(wr_pos), 15'b0, full};
            OFS_IPEND: bus_rdata = 32'(pend_q);
            OFS_IMASK: bus_rdata = 32'(mask_q);
            OFS_CAP:   bus_rdata = 32'(DEPTH - 1);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbx_rx_chk.sv
// Module: checker for the receive queue. Keeps a shadow fill count from
// port activity and checks flags and interrupt behaviour against it.
module mbx_rx_chk #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          bus_wr,
    input logic [5:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          full,
    input logic [AW-1:0] rd_pos,
    input logic          pend_q,
    input logic          mask0
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt;
    logic          fire;
    logic          popw;
    logic          clrw;
    logic          iclr;

    // Port-level events.
    always_comb begin
        fire = in_valid && in_ready;
        popw = bus_wr && (bus_addr == 6'h0C) && bus_wdata[0];
        clrw = bus_wr && (bus_addr == 6'h10) && (bus_wdata == 32'd0);
        iclr = bus_wr && (bus_addr == 6'h18) && bus_wdata[0];
    end

    // Shadow fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || clrw) cnt <= '0;
        else cnt <= cnt + CW'(fire) - CW'(popw && (cnt != '0));
    end

    assert_full_matches_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full == (cnt == CW'(DEPTH)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DEPTH)) |-> !in_ready);

    assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (popw && (cnt == '0) && !clrw) |=> $stable(rd_pos));

    assert_clear_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clrw |=> (!full && (rd_pos == '0)));

    assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !mask0) |=> pend_q);

    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr && !fire) |=> !pend_q);
endmodule

bind mbx_rx_fifo mbx_rx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .full      (full),
    .rd_pos    (rd_pos),
    .pend_q    (pend_q),
    .mask0     (mask_q[0])
);

// File: tb/sim_mbx_rx_fifo.sv
module sim_mbx_rx_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_chan = '0;
    logic [31:0] in_lo = '0;
    logic [31:0] in_hi = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic last_ready;

    // Reference model of the queue.
    logic [2:0]  m_chan [DEPTH];
    logic [31:0] m_lo   [DEPTH];
    logic [31:0] m_hi   [DEPTH];
    int m_wr = 0, m_rd = 0, m_cnt = 0, seq = 0;

    mbx_rx_fifo #(.DEPTH(DEPTH)) u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                summary();
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus: optional push and optional register write.
    task automatic cyc(input logic pv, input logic [2:0] ch, input logic [31:0] lo,
                       input logic [31:0] hi, input logic w, input logic [5:0] a,
                       input logic [31:0] d);
        @(negedge clk);
        in_valid = pv; in_chan = ch; in_lo = lo; in_hi = hi;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        #1 last_ready = in_ready;
        @(negedge clk);
        in_valid = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] pat_lo(input int s);
        return (32'(s) * 32'h01030507) ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] pat_hi(input int s);
        return ~pat_lo(s) + 32'(s);
    endfunction

    // Push the next pattern; the model accepts it only when there is room.
    task automatic do_push(input string tag);
        logic [2:0] ch;
        ch = 3'(seq * 5 + 1);
        cyc(1'b1, ch, pat_lo(seq), pat_hi(seq), 1'b0, 6'h00, 0);
        chk({tag, " ready"}, 32'(last_ready), 32'(m_cnt < DEPTH));
        if (m_cnt < DEPTH) begin
            m_chan[m_wr] = ch; m_lo[m_wr] = pat_lo(seq); m_hi[m_wr] = pat_hi(seq);
            m_wr = (m_wr + 1) % DEPTH; m_cnt++;
        end
        seq++;
    endtask

    task automatic do_pop();
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h0C, 32'h1);
        if (m_cnt > 0) begin m_rd = (m_rd + 1) % DEPTH; m_cnt--; end
    endtask

    task automatic chk_stat(input string tag);
        logic [31:0] v;
        rd(6'h14, v);
        chk(tag, v, {8'(m_rd), 8'(m_wr), 15'b0, (m_cnt == DEPTH)});
    endtask

    task automatic chk_head(input string tag);
        logic [31:0] v;
        rd(6'h00, v); chk({tag, " chan"}, v, (m_cnt == 0) ? 0 : 32'(m_chan[m_rd]));
        rd(6'h04, v); chk({tag, " lo"},   v, (m_cnt == 0) ? 0 : m_lo[m_rd]);
        rd(6'h08, v); chk({tag, " hi"},   v, (m_cnt == 0) ? 0 : m_hi[m_rd]);
    endtask

    task automatic do_clear();
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h10, 32'h0);
        m_wr = 0; m_rd = 0; m_cnt = 0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R9 capacity, R12 empty head
        chk_stat("R1 status");
        rd(6'h18, v); chk("R1 pending", v, 0);
        rd(6'h1C, v); chk("R1 mask", v, 32'h1F);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ready", 32'(in_ready), 1);
        rd(6'h24, v); chk("R9 capacity", v, DEPTH - 1);
        chk_head("R12 empty head");

        // R2 R4 R6: every start offset and every fill level
        for (int off = 0; off < DEPTH; off++) begin
            for (int fill = 1; fill <= DEPTH; fill++) begin
                do_clear();
                for (int k = 0; k < off; k++) do_push("R2 pre");
                for (int k = 0; k < off; k++) do_pop();
                chk_stat("R4 R6 offset status");
                for (int k = 0; k < fill; k++) begin
                    do_push("R2 push");
                    chk_stat("R2 R6 after push");
                end
                for (int k = 0; k < fill; k++) begin
                    chk_head("R2 head");
                    do_pop();
                    chk_stat("R4 after pop");
                end
                chk_head("R12 drained");
            end
        end

        // R3 full: refused pushes keep contents
        do_clear();
        for (int k = 0; k < DEPTH; k++) do_push("R3 fill");
        chk_stat("R3 full status");
        chk("R3 ready low", 32'(in_ready), 0);
        do_push("R3 refused");
        do_push("R3 refused again");
        chk_stat("R3 status kept");
        for (int k = 0; k < DEPTH; k++) begin chk_head("R3 contents"); do_pop(); end
        chk_stat("R3 drained");

        // R4 pop command with bit 0 clear is ignored
        do_push("R4 setup"); do_push("R4 setup");
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h0C, 32'hFFFF_FFFE);
        chk_stat("R4 bit0 clear ignored");
        chk_head("R4 head kept");

        // R5 pop on empty ignored
        do_clear();
        do_pop(); do_pop();
        chk_stat("R5 empty pop");

        // R7 simultaneous push and pop
        do_push("R7 setup"); do_push("R7 setup"); do_push("R7 setup");
        cyc(1'b1, 3'd6, 32'h1111_2222, 32'h3333_4444, 1'b1, 6'h0C, 32'h1);
        chk("R7 ready", 32'(last_ready), 1);
        m_chan[m_wr] = 3'd6; m_lo[m_wr] = 32'h1111_2222; m_hi[m_wr] = 32'h3333_4444;
        m_wr = (m_wr + 1) % DEPTH; m_rd = (m_rd + 1) % DEPTH;
        chk_stat("R7 both advance");
        chk_head("R7 head");
        // R7 at full - 1: push plus pop keeps full clear
        while (m_cnt < DEPTH - 1) do_push("R7 fill");
        cyc(1'b1, 3'd2, 32'h7, 32'h8, 1'b1, 6'h0C, 32'h1);
        m_chan[m_wr] = 3'd2; m_lo[m_wr] = 32'h7; m_hi[m_wr] = 32'h8;
        m_wr = (m_wr + 1) % DEPTH; m_rd = (m_rd + 1) % DEPTH;
        chk_stat("R7 near full");
        // R5 push and pop together on empty: pop ignored, push kept
        do_clear();
        cyc(1'b1, 3'd3, 32'hAB, 32'hCD, 1'b1, 6'h0C, 32'h1);
        m_chan[0] = 3'd3; m_lo[0] = 32'hAB; m_hi[0] = 32'hCD; m_wr = 1; m_cnt = 1;
        chk_stat("R5 pop with push on empty");
        chk_head("R5 head kept");

        // R8 clear command
        do_push("R8 setup"); do_push("R8 setup");
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h10, 32'h1);
        chk_stat("R8 nonzero ignored");
        cyc(1'b1, 3'd1, 32'h9, 32'h9, 1'b1, 6'h10, 32'h0);
        chk("R8 ready low during clear", 32'(last_ready), 0);
        m_wr = 0; m_rd = 0; m_cnt = 0;
        chk_stat("R8 cleared");

        // R10 masked push leaves pending clear
        do_push("R10 masked");
        rd(6'h18, v); chk("R10 masked pending", v, 0);
        chk("R10 masked irq", 32'(irq), 0);
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h1C, 32'hFFFF_FFFE);
        rd(6'h1C, v); chk("R10 mask readback", v, 32'h1E);
        chk("R10 no irq without push", 32'(irq), 0);
        do_push("R10 unmasked");
        rd(6'h18, v); chk("R10 pending", v, 1);
        chk("R10 irq", 32'(irq), 1);
        // R11 clear
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h18, 32'h1);
        rd(6'h18, v); chk("R11 cleared", v, 0);
        chk("R11 irq low", 32'(irq), 0);
        // R11 clear with push in the same cycle
        cyc(1'b1, 3'd4, 32'h55, 32'h66, 1'b1, 6'h18, 32'h1);
        m_chan[m_wr] = 3'd4; m_lo[m_wr] = 32'h55; m_hi[m_wr] = 32'h66;
        m_wr = (m_wr + 1) % DEPTH; m_cnt++;
        rd(6'h18, v); chk("R11 push wins", v, 1);
        chk("R11 irq stays", 32'(irq), 1);
        // R10 masking hides the line but not the pending bit
        cyc(1'b0, 3'd0, 0, 0, 1'b1, 6'h1C, 32'h1);
        chk("R10 irq masked", 32'(irq), 0);
        rd(6'h18, v); chk("R10 pending kept", v, 1);
        chk_stat("R10 R6 status");

        summary();
    end
endmodule